// File: doc/BRIEF.md
# Bus Timeout Detector

This block watches the two lines of a two-wire serial bus and raises a sticky timeout flag when either of two programmable limits is crossed. All timing runs from a free-running kernel clock. The bus lines pass through a two-flop synchronizer before any timer sees them. One shared prescaler produces a long tick every 2048 kernel cycles and a short tick every 4 cycles.

Timer A is a level timer. It has two modes. In clock-low mode it counts long ticks while the clock line stays low. In idle mode it counts short ticks while both lines stay high. The count restarts whenever the watched condition drops, so only one unbroken interval counts. Timer B is an accumulator. It counts long ticks while the local device stretches the clock line low, and it keeps its count across separate stretch periods. It restarts on a start/stop indication or when it is disabled.

Both timers are configured through a small register-style write port: a select bit, a 14-bit data word and a write strobe. Each timer's reload value, and Timer A's mode bit, cannot be changed while that timer is enabled. A clear pulse drops the flag.

Top module: `bus_timeout_monitor`

## Requirements
- R1: After reset, `tmo_flag` is 0 and both read-back words are 0.
- R2: A write with `cfg_sel`=0 updates Timer A and a write with `cfg_sel`=1 updates Timer B. The word layout is: bit 13 is the enable, bit 12 is the mode (1 = idle mode, Timer A only) and bits 11:0 are the reload value. Read-back uses the same layout, and bit 12 of the Timer B word always reads 0.
- R3: While Timer A is enabled, a write to it changes only the enable bit. Its reload and mode bits keep their values.
- R4: While Timer B is enabled, a write to it changes only the enable bit. Its reload bits keep their values.
- R5: In clock-low mode with reload r, a clock line held low at the pin sets the flag. The flag is still 0 after the 2+2048·r-th clock edge from the change, and it is 1 by the 2050+2048·r-th edge.
- R6: In idle mode with reload r, both lines held high at the pins set the flag. The flag is still 0 after the 2+4·r-th edge and is 1 by the 6+4·r-th edge.
- R7: Any break in Timer A's condition that lasts at least one cycle restarts its count from zero.
- R8: Timer B counts one unit for each 2048-cycle prescaler tick that falls inside a stretch period. It sets the flag on the (r+1)-th counted unit, summed across separate stretch periods.
- R9: Timer B's count returns to zero on a `bus_evt_in` pulse and whenever Timer B is disabled.
- R10: The flag stays at 1 until `flag_clr` is pulsed. A clear with no timeout in the same cycle makes the flag 0 on the next edge.
- R11: A timeout in the same cycle as a clear leaves the flag at 1.
- R12: A disabled timer never sets the flag, whatever the lines or the stretch input do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| stretch_in | input | 1 | High while the local device holds the clock line low |
| bus_evt_in | input | 1 | One-cycle start or stop indication |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Write target: 0 selects Timer A, 1 selects Timer B |
| cfg_wdata | input | 14 | Configuration word |
| flag_clr | input | 1 | Clears the timeout flag |
| cfg_a_rd | output | 14 | Timer A configuration read-back |
| cfg_b_rd | output | 14 | Timer B configuration read-back |
| tmo_flag | output | 1 | Sticky timeout flag |

## Verification
Some rules are checked on every cycle by the assertions. These are the flag's set/clear priority, the write locks on reload and mode, the rule that a timer hit needs its enable (and, for Timer B, an active stretch), the reset of Timer B's count on a bus event, and the bound of Timer A's count against its reload. Other behaviour is visible only at the pins over long stretches of time, so only the bench scenarios can show it. This covers the exact timing windows in both Timer A modes, the restart after a short break in the condition, Timer B's sum across separate stretch periods, and the clear-versus-timeout race under a short period.

// File: rtl/tmo_pkg.sv
package tmo_pkg;
    localparam int RELOAD_W = 12;
    localparam int LONG_W   = 11;
    localparam int SHORT_W  = 2;
    localparam int CFG_W    = RELOAD_W + 2;

    typedef struct packed {
        logic                en;
        logic                idle;
        logic [RELOAD_W-1:0] reload;
    } tmr_cfg_t;

    // Next Timer A state after a write: reload and mode locked while enabled.
    function automatic tmr_cfg_t upd_a(tmr_cfg_t cur, logic [CFG_W-1:0] d);
        tmr_cfg_t n;
        n    = cur;
        n.en = d[CFG_W-1];
        if (!cur.en) begin
            n.idle   = d[CFG_W-2];
            n.reload = d[RELOAD_W-1:0];
        end
        return n;
    endfunction

    // Next Timer B state after a write: no mode bit, reload locked while enabled.
    function automatic tmr_cfg_t upd_b(tmr_cfg_t cur, logic [CFG_W-1:0] d);
        tmr_cfg_t n;
        n      = cur;
        n.en   = d[CFG_W-1];
        n.idle = 1'b0;
        if (!cur.en) n.reload = d[RELOAD_W-1:0];
        return n;
    endfunction
endpackage

// File: rtl/tmo_sync.sv
module tmo_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[i] <= 1'b1;
                q[i]      <= 1'b1;
            end else begin
                stage1[i] <= d[i];
                q[i]      <= stage1[i];
            end
        end
    end
endmodule

// File: rtl/tmo_prescale.sv
module tmo_prescale #(
    parameter int LONG_W  = tmo_pkg::LONG_W,
    parameter int SHORT_W = tmo_pkg::SHORT_W
) (
    input  logic clk,
    input  logic rst,
    output logic tick_long,
    output logic tick_short
);
    logic [LONG_W-1:0] pre_cnt;

    always_ff @(posedge clk) begin
        if (rst) pre_cnt <= '0;
        else     pre_cnt <= pre_cnt + 1'b1;
    end

    assign tick_long  = &pre_cnt;
    assign tick_short = &pre_cnt[SHORT_W-1:0];
endmodule

// File: rtl/tmo_level_timer.sv
module tmo_level_timer #(
    parameter int RELOAD_W = tmo_pkg::RELOAD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                idle_mode,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                scl_s,
    input  logic                sda_s,
    input  logic                tick_long,
    input  logic                tick_short,
    output logic                hit,
    output logic [RELOAD_W-1:0] cnt
);
    logic cond;
    logic tick;

    always_comb begin
        cond = idle_mode ? (scl_s & sda_s) : ~scl_s;
        tick = idle_mode ? tick_short : tick_long;
        hit  = en && cond && tick && (cnt == reload);
    end

    // Count only while the condition holds without a break.
    always_ff @(posedge clk) begin
        if (rst || !en || !cond) cnt <= '0;
        else if (tick)           cnt <= hit ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/tmo_stretch_acc.sv
module tmo_stretch_acc #(
    parameter int RELOAD_W = tmo_pkg::RELOAD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic [RELOAD_W-1:0] reload,
    input  logic                stretch,
    input  logic                bus_evt,
    input  logic                tick_long,
    output logic                hit,
    output logic [RELOAD_W-1:0] cnt
);
    assign hit = en && !bus_evt && stretch && tick_long && (cnt == reload);

    // The count is kept between stretch periods; only an event or a disable clears it.
    always_ff @(posedge clk) begin
        if (rst || !en || bus_evt)  cnt <= '0;
        else if (stretch && tick_long) cnt <= hit ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/bus_timeout_monitor.sv
module bus_timeout_monitor
    import tmo_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             stretch_in,
    input  logic             bus_evt_in,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             flag_clr,
    output logic [CFG_W-1:0] cfg_a_rd,
    output logic [CFG_W-1:0] cfg_b_rd,
    output logic             tmo_flag
);
    tmr_cfg_t            cfg_a;
    tmr_cfg_t            cfg_b;
    logic [1:0]          lines_s;
    logic                tick_long;
    logic                tick_short;
    logic                hit_a;
    logic                hit_b;
    logic [RELOAD_W-1:0] cnt_a;
    logic [RELOAD_W-1:0] cnt_b;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_a <= '0;
            cfg_b <= '0;
        end else if (cfg_we) begin
            if (!cfg_sel) cfg_a <= upd_a(cfg_a, cfg_wdata);
            else          cfg_b <= upd_b(cfg_b, cfg_wdata);
        end
    end

    assign cfg_a_rd = cfg_a;
    assign cfg_b_rd = cfg_b;

    tmo_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({scl_in, sda_in}),
        .q   (lines_s)
    );

    tmo_prescale #(.LONG_W(LONG_W), .SHORT_W(SHORT_W)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .tick_long  (tick_long),
        .tick_short (tick_short)
    );

    tmo_level_timer #(.RELOAD_W(RELOAD_W)) u_tmr_a (
        .clk        (clk),
        .rst        (rst),
        .en         (cfg_a.en),
        .idle_mode  (cfg_a.idle),
        .reload     (cfg_a.reload),
        .scl_s      (lines_s[1]),
        .sda_s      (lines_s[0]),
        .tick_long  (tick_long),
        .tick_short (tick_short),
        .hit        (hit_a),
        .cnt        (cnt_a)
    );

    tmo_stretch_acc #(.RELOAD_W(RELOAD_W)) u_tmr_b (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_b.en),
        .reload    (cfg_b.reload),
        .stretch   (stretch_in),
        .bus_evt   (bus_evt_in),
        .tick_long (tick_long),
        .hit       (hit_b),
        .cnt       (cnt_b)
    );

    // A new timeout beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (rst) tmo_flag <= 1'b0;
        else     tmo_flag <= (tmo_flag & ~flag_clr) | hit_a | hit_b;
    end
endmodule

// File: rtl/tmo_checker.sv
module tmo_checker
    import tmo_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                cfg_we,
    input logic                cfg_sel,
    input logic                flag_clr,
    input logic                stretch_in,
    input logic                bus_evt_in,
    input logic                tmo_flag,
    input tmr_cfg_t            cfg_a,
    input tmr_cfg_t            cfg_b,
    input logic                hit_a,
    input logic                hit_b,
    input logic [RELOAD_W-1:0] cnt_a,
    input logic [RELOAD_W-1:0] cnt_b
);
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        tmo_flag && !flag_clr |=> tmo_flag);

    a_r10_clear: assert property (@(posedge clk) disable iff (rst)
        flag_clr && !hit_a && !hit_b |=> !tmo_flag);

    a_r11_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit_a || hit_b |=> tmo_flag);

    a_r3_lock_a: assert property (@(posedge clk) disable iff (rst)
        cfg_a.en && cfg_we && !cfg_sel |=> $stable(cfg_a.reload) && $stable(cfg_a.idle));

    a_r4_lock_b: assert property (@(posedge clk) disable iff (rst)
        cfg_b.en && cfg_we && cfg_sel |=> $stable(cfg_b.reload));

    a_r12_hit_a_enabled: assert property (@(posedge clk) disable iff (rst)
        hit_a |-> cfg_a.en);

    a_r12_hit_b_enabled: assert property (@(posedge clk) disable iff (rst)
        hit_b |-> cfg_b.en && stretch_in);

    a_r9_evt_clears: assert property (@(posedge clk) disable iff (rst)
        bus_evt_in |=> cnt_b == '0);

    a_r5_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cfg_a.en |-> cnt_a <= cfg_a.reload);
endmodule

bind bus_timeout_monitor tmo_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .flag_clr   (flag_clr),
    .stretch_in (stretch_in),
    .bus_evt_in (bus_evt_in),
    .tmo_flag   (tmo_flag),
    .cfg_a      (cfg_a),
    .cfg_b      (cfg_b),
    .hit_a      (hit_a),
    .hit_b      (hit_b),
    .cnt_a      (cnt_a),
    .cnt_b      (cnt_b)
);

// File: tb/bus_timeout_monitor_tb.sv
module bus_timeout_monitor_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_in = 1'b1;
    logic        sda_in = 1'b1;
    logic        stretch_in = 1'b0;
    logic        bus_evt_in = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [13:0] cfg_wdata = '0;
    logic        flag_clr = 1'b0;
    logic [13:0] cfg_a_rd;
    logic [13:0] cfg_b_rd;
    logic        tmo_flag;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [13:0] ma = '0;
    logic [13:0] mb = '0;

    always #5 clk = ~clk;

    bus_timeout_monitor u_dut (
        .clk        (clk),
        .rst        (rst),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .stretch_in (stretch_in),
        .bus_evt_in (bus_evt_in),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .flag_clr   (flag_clr),
        .cfg_a_rd   (cfg_a_rd),
        .cfg_b_rd   (cfg_b_rd),
        .tmo_flag   (tmo_flag)
    );

    // Expected read-back after a write (R2, R3, R4).
    function automatic logic [13:0] exp_a(logic [13:0] cur, logic [13:0] d);
        return cur[13] ? {d[13], cur[12:0]} : d;
    endfunction

    function automatic logic [13:0] exp_b(logic [13:0] cur, logic [13:0] d);
        return cur[13] ? {d[13], 1'b0, cur[11:0]} : {d[13], 1'b0, d[11:0]};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_edges(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic sel, logic [13:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        wait_edges(1);
        cfg_we = 1'b0;
        if (!sel) ma = exp_a(ma, d);
        else      mb = exp_b(mb, d);
    endtask

    task automatic clr_pulse();
        flag_clr = 1'b1;
        wait_edges(1);
        flag_clr = 1'b0;
    endtask

    task automatic stretch_piece();
        stretch_in = 1'b1;
        wait_edges(2048);
        stretch_in = 1'b0;
        wait_edges(300);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL watchdog: actual=%0d expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int ones;
        void'($urandom(32'd1234));
        wait_edges(4);
        rst = 1'b0;
        wait_edges(1);

        // R1: reset state
        chk("R1 flag", tmo_flag, 0);
        chk("R1 cfg_a_rd", cfg_a_rd, 0);
        chk("R1 cfg_b_rd", cfg_b_rd, 0);

        // R2: random writes, read-back against model
        for (int i = 0; i < 40; i++) begin
            logic sel;
            logic [13:0] d;
            sel = 1'($urandom);
            d   = 14'($urandom);
            wr(sel, d);
            chk("R2 cfg_a_rd", cfg_a_rd, ma);
            chk("R2 cfg_b_rd", cfg_b_rd, mb);
        end
        wr(1'b0, 14'h0); wr(1'b0, 14'h0);
        wr(1'b1, 14'h0); wr(1'b1, 14'h0);
        clr_pulse();
        chk("R2 cleared a", cfg_a_rd, 0);
        chk("R2 cleared b", cfg_b_rd, 0);

        // R3: Timer A lock
        wr(1'b0, 14'h2005);
        chk("R3 enable write", cfg_a_rd, 14'h2005);
        wr(1'b0, 14'h3009);
        chk("R3 locked while enabled", cfg_a_rd, 14'h2005);
        wr(1'b0, 14'h1009);
        chk("R3 disable keeps reload", cfg_a_rd, 14'h0005);
        wr(1'b0, 14'h1009);
        chk("R3 unlocked write", cfg_a_rd, 14'h1009);
        wr(1'b0, 14'h0);

        // R4: Timer B lock
        wr(1'b1, 14'h2003);
        chk("R4 enable write", cfg_b_rd, 14'h2003);
        wr(1'b1, 14'h200A);
        chk("R4 locked while enabled", cfg_b_rd, 14'h2003);
        wr(1'b1, 14'h0);
        chk("R4 disable keeps reload", cfg_b_rd, 14'h0003);
        wr(1'b1, 14'h0);
        chk("R4 unlocked write", cfg_b_rd, 14'h0);
        chk("R4 no flag from config", tmo_flag, 0);

        // R5: clock-low mode, reload 1
        wr(1'b0, 14'h2001);
        scl_in = 1'b0;
        wait_edges(2 + 2048);
        chk("R5 not before window", tmo_flag, 0);
        wait_edges(2048);
        chk("R5 set by window end", tmo_flag, 1);
        // R10: sticky, then clear
        scl_in = 1'b1;
        wr(1'b0, 14'h0);
        wait_edges(100);
        chk("R10 sticky", tmo_flag, 1);
        clr_pulse();
        chk("R10 clear", tmo_flag, 0);

        // R7 and R6: idle mode, reload 5, with a short break
        sda_in = 1'b0;
        wr(1'b0, 14'h3005);
        wait_edges(4);
        sda_in = 1'b1;
        wait_edges(20);
        sda_in = 1'b0;
        wait_edges(2);
        sda_in = 1'b1;
        wait_edges(22);
        chk("R7 break restarts count", tmo_flag, 0);
        wait_edges(4);
        chk("R6 idle timeout", tmo_flag, 1);

        // R11: reload 0 gives a timeout every 4 cycles; clear held high
        wr(1'b0, 14'h0);
        wr(1'b0, 14'h3000);
        wait_edges(8);
        ones = 0;
        flag_clr = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wait_edges(1);
            if (tmo_flag) ones++;
        end
        flag_clr = 1'b0;
        chk("R11 timeout beats clear", ones, 2);
        wr(1'b0, 14'h0);
        clr_pulse();
        chk("R10 clear after disable", tmo_flag, 0);

        // R12: both disabled, conditions present
        scl_in = 1'b0;
        stretch_in = 1'b1;
        wait_edges(4200);
        chk("R12 disabled timers silent", tmo_flag, 0);
        stretch_in = 1'b0;
        scl_in = 1'b1;
        wait_edges(4);

        // R8: cumulative stretch, reload 2
        wr(1'b1, 14'h2002);
        stretch_piece();
        stretch_piece();
        chk("R8 two units", tmo_flag, 0);
        stretch_piece();
        chk("R8 third unit sets flag", tmo_flag, 1);
        clr_pulse();
        chk("R10 clear after R8", tmo_flag, 0);

        // R9: bus event resets accumulator
        stretch_piece();
        stretch_piece();
        bus_evt_in = 1'b1;
        wait_edges(1);
        bus_evt_in = 1'b0;
        stretch_piece();
        stretch_piece();
        chk("R9 event restarts count", tmo_flag, 0);
        stretch_piece();
        chk("R9 count after event", tmo_flag, 1);
        clr_pulse();

        // R9: disable resets accumulator
        stretch_piece();
        stretch_piece();
        wr(1'b1, 14'h0);
        wr(1'b1, 14'h2002);
        chk("R9 re-enable readback", cfg_b_rd, 14'h2002);
        stretch_piece();
        chk("R9 disable restarts count", tmo_flag, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule